// File: doc/BRIEF.md
# LPC Firmware Window Remapper

This block sits between a host-side LPC firmware-cycle decoder and an on-chip bus master. Each incoming firmware request carries a 32-bit address and a size code. The block decides whether the request falls inside a programmable window. It also rebuilds the upper half of the address for the chip bus. Only the upper 16 address bits are decoded and rewritten. The lower 16 bits and the size code pass through unchanged.

Four 16-bit fields set the window:

- **Match base:** the value the upper address bits are compared against.
- **Ignore mask:** a 1 in a bit position leaves that bit out of the comparison.
- **Target base:** the source of the rewritten upper bits.
- **Substitute mask:** a 1 in a bit position takes that output bit from the target base; a 0 keeps the incoming bit.

All four fields are loaded through a one-cycle register write port. A result with a hit flag and the translated address appears one clock after each request.

A typical setting is target base 0x3000, match base 0x0E00, substitute mask 0xFE00 and ignore mask 0x01FF. It maps LPC 0x0E000000–0x0FFFFFFF onto 0x30000000–0x31FFFFFF. A second setting is target base 0x3000, match base 0xFCE0, substitute mask 0xFFE0 and ignore mask 0x001F. It maps LPC 0xFCE00000–0xFCFFFFFF onto 0x30000000–0x301FFFFF.

Top module: `lfw_remap`

## Requirements
- R1: After a synchronous reset, rsp_valid, rsp_hit, rsp_addr and rsp_size are all zero, and all four window fields are zero.
- R2: A request accepted at a clock edge (req_valid high) gives rsp_valid high for exactly the following cycle. With no request, rsp_valid is low in the following cycle.
- R3: rsp_hit is high only when every bit i in 31:16 of req_addr with ignore-mask bit i-16 equal to 0 equals match-base bit i-16.
- R4: When rsp_hit is high, bit i in 31:16 of rsp_addr equals target-base bit i-16 where substitute-mask bit i-16 is 1, and equals req_addr bit i where it is 0. When rsp_hit is low, rsp_addr has no meaning.
- R5: rsp_addr[15:0] equals req_addr[15:0] of the same request, for hits and misses.
- R6: rsp_size equals req_size of the same request, unchanged. The codes are 0 for 1 byte, 1 for 2 bytes and 2 for 4 bytes.
- R7: With all fields zero, a request hits only if req_addr[31:16] is 0x0000. The hit then returns the address unchanged.
- R8: A write with cfg_we high loads cfg_wdata into the field chosen by cfg_sel and leaves the other three fields unchanged. The cfg_sel codes are 0 for match base, 1 for ignore mask, 2 for target base and 3 for substitute mask.
- R9: A request in the same cycle as a field write is translated with the field values held before that write. The new value applies from the next request on.
- R10: rsp_hit is low whenever rsp_valid is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Window field write strobe |
| cfg_sel | input | 2 | Field select: 0 match base, 1 ignore mask, 2 target base, 3 substitute mask |
| cfg_wdata | input | 16 | Field write data |
| req_valid | input | 1 | Firmware request present |
| req_addr | input | 32 | LPC firmware address |
| req_size | input | 2 | Access size code (0: 1 byte, 1: 2 bytes, 2: 4 bytes) |
| rsp_valid | output | 1 | Result present (one cycle after request) |
| rsp_hit | output | 1 | Request fell inside the window |
| rsp_addr | output | 32 | Translated bus address, meaningful only on hit |
| rsp_size | output | 2 | Size code passed through |

## Verification
A field write and a request can fall in the same clock edge. The request must see the field values from before the write. The bench provokes this by raising cfg_we and req_valid in one cycle, with a new match base that would turn a hit into a miss. It then checks that the result still reflects the old window. It follows with a second request that must reflect the new window, so both orderings of the collision are judged at the outputs.

// File: rtl/lfw_pkg.sv
package lfw_pkg;
  localparam int ADDR_W  = 32;
  localparam int HI_W    = 16;
  localparam int LO_W    = ADDR_W - HI_W;
  localparam int SIZE_W  = 2;
  localparam int NFIELD  = 4;
  localparam int SEL_W   = $clog2(NFIELD);

  typedef enum logic [SEL_W-1:0] {
    FLD_MBASE = 2'd0,
    FLD_IGN   = 2'd1,
    FLD_TBASE = 2'd2,
    FLD_SUBST = 2'd3
  } fld_sel_e;
endpackage

// File: rtl/lfw_cfg_regs.sv
module lfw_cfg_regs #(
  parameter int HI_W  = 16,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [SEL_W-1:0] sel,
  input  logic [HI_W-1:0]  wdata,
  output logic [HI_W-1:0]  mbase,
  output logic [HI_W-1:0]  ign,
  output logic [HI_W-1:0]  tbase,
  output logic [HI_W-1:0]  subst
);
  import lfw_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      mbase <= '0;
      ign   <= '0;
      tbase <= '0;
      subst <= '0;
    end else if (we) begin
      case (sel)
        FLD_MBASE: mbase <= wdata;
        FLD_IGN:   ign   <= wdata;
        FLD_TBASE: tbase <= wdata;
        default:   subst <= wdata;
      endcase
    end
  end
endmodule

// File: rtl/lfw_match.sv
module lfw_match #(
  parameter int HI_W = 16
) (
  input  logic [HI_W-1:0] hi_addr,
  input  logic [HI_W-1:0] mbase,
  input  logic [HI_W-1:0] ign,
  output logic            hit
);
  logic [HI_W-1:0] bit_ok;

  for (genvar i = 0; i < HI_W; i++) begin : g_bit
    assign bit_ok[i] = ign[i] | ~(hi_addr[i] ^ mbase[i]);
  end

  assign hit = &bit_ok;
endmodule

// File: rtl/lfw_merge.sv
module lfw_merge #(
  parameter int HI_W = 16
) (
  input  logic [HI_W-1:0] hi_addr,
  input  logic [HI_W-1:0] tbase,
  input  logic [HI_W-1:0] subst,
  output logic [HI_W-1:0] hi_out
);
  for (genvar i = 0; i < HI_W; i++) begin : g_bit
    assign hi_out[i] = subst[i] ? tbase[i] : hi_addr[i];
  end
endmodule

// File: rtl/lfw_remap.sv
module lfw_remap #(
  parameter int ADDR_W = lfw_pkg::ADDR_W,
  parameter int HI_W   = lfw_pkg::HI_W,
  parameter int SIZE_W = lfw_pkg::SIZE_W,
  parameter int SEL_W  = lfw_pkg::SEL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic [HI_W-1:0]   cfg_wdata,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [SIZE_W-1:0] req_size,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic [SIZE_W-1:0] rsp_size
);
  localparam int LO_W = ADDR_W - HI_W;

  logic [HI_W-1:0] f_mbase, f_ign, f_tbase, f_subst;
  logic [HI_W-1:0] hi_in, hi_new;
  logic            win_hit;

  assign hi_in = req_addr[ADDR_W-1:LO_W];

  lfw_cfg_regs #(.HI_W(HI_W), .SEL_W(SEL_W)) u_cfg (
    .clk   (clk),
    .rst   (rst),
    .we    (cfg_we),
    .sel   (cfg_sel),
    .wdata (cfg_wdata),
    .mbase (f_mbase),
    .ign   (f_ign),
    .tbase (f_tbase),
    .subst (f_subst)
  );

  lfw_match #(.HI_W(HI_W)) u_match (
    .hi_addr (hi_in),
    .mbase   (f_mbase),
    .ign     (f_ign),
    .hit     (win_hit)
  );

  lfw_merge #(.HI_W(HI_W)) u_merge (
    .hi_addr (hi_in),
    .tbase   (f_tbase),
    .subst   (f_subst),
    .hi_out  (hi_new)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_addr  <= '0;
      rsp_size  <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_hit   <= req_valid & win_hit;
      if (req_valid) begin
        rsp_addr <= {hi_new, req_addr[LO_W-1:0]};
        rsp_size <= req_size;
      end
    end
  end
endmodule

// File: rtl/lfw_remap_chk.sv
module lfw_remap_chk #(
  parameter int ADDR_W = 32,
  parameter int HI_W   = 16,
  parameter int SIZE_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_addr,
  input logic [SIZE_W-1:0] req_size,
  input logic              rsp_valid,
  input logic              rsp_hit,
  input logic [ADDR_W-1:0] rsp_addr,
  input logic [SIZE_W-1:0] rsp_size,
  input logic [HI_W-1:0]   f_mbase,
  input logic [HI_W-1:0]   f_ign
);
  localparam int LO_W = ADDR_W - HI_W;

  // R2
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  // R2
  rsp_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);

  // R10
  hit_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_hit |-> rsp_valid);

  // R5
  low_pass_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_addr[LO_W-1:0] == $past(req_addr[LO_W-1:0]));

  // R6
  size_pass_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_size == $past(req_size));

  // R3
  hit_rule_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_hit ==
      $past((((req_addr[ADDR_W-1:LO_W] ^ f_mbase) & ~f_ign) == '0)));
endmodule

bind lfw_remap lfw_remap_chk #(.ADDR_W(ADDR_W), .HI_W(HI_W), .SIZE_W(SIZE_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_addr  (req_addr),
  .req_size  (req_size),
  .rsp_valid (rsp_valid),
  .rsp_hit   (rsp_hit),
  .rsp_addr  (rsp_addr),
  .rsp_size  (rsp_size),
  .f_mbase   (f_mbase),
  .f_ign     (f_ign)
);

// File: tb/lfw_remap_tb.sv
`timescale 1ns/1ps
module lfw_remap_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_we;
  logic [1:0]  cfg_sel;
  logic [15:0] cfg_wdata;
  logic        req_valid;
  logic [31:0] req_addr;
  logic [1:0]  req_size;
  logic        rsp_valid, rsp_hit;
  logic [31:0] rsp_addr;
  logic [1:0]  rsp_size;

  int n_chk = 0;
  int n_bad = 0;

  logic [15:0] m_mbase, m_ign, m_tbase, m_subst;

  always #2.5 clk = ~clk;

  lfw_remap u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_addr(req_addr), .req_size(req_size),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_addr(rsp_addr), .rsp_size(rsp_size)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_set(input logic [1:0] s, input logic [15:0] d);
    case (s)
      2'd0: m_mbase = d;
      2'd1: m_ign   = d;
      2'd2: m_tbase = d;
      default: m_subst = d;
    endcase
  endtask

  task automatic cfg_write(input logic [1:0] s, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    model_set(s, d);
  endtask

  function automatic logic model_hit(input logic [31:0] a);
    return (((a[31:16] ^ m_mbase) & ~m_ign) == 16'h0);
  endfunction

  function automatic logic [31:0] model_addr(input logic [31:0] a);
    return {(m_tbase & m_subst) | (a[31:16] & ~m_subst), a[15:0]};
  endfunction

  // drive one request, check result in the following cycle
  task automatic do_req(input string tag, input logic [31:0] a, input logic [1:0] sz);
    logic eh;
    logic [31:0] ea;
    eh = model_hit(a);
    ea = model_addr(a);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_size = sz;
    @(negedge clk);
    req_valid = 1'b0;
    check({tag, " R2 valid"}, {31'd0, rsp_valid}, 32'd1);
    check({tag, " R3 hit"}, {31'd0, rsp_hit}, {31'd0, eh});
    if (eh) check({tag, " R4 addr"}, rsp_addr, ea);
    check({tag, " R5 low"}, {16'd0, rsp_addr[15:0]}, {16'd0, a[15:0]});
    check({tag, " R6 size"}, {30'd0, rsp_size}, {30'd0, sz});
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1 valid", {31'd0, rsp_valid}, 32'd0);
    check("R1 hit", {31'd0, rsp_hit}, 32'd0);
    check("R1 addr", rsp_addr, 32'd0);
    check("R1 size", {30'd0, rsp_size}, 32'd0);
  endtask

  task automatic t_zero_cfg;
    do_req("R7 zero-hit", 32'h0000_1234, 2'd2);
    check("R7 unchanged", rsp_addr, 32'h0000_1234);
    do_req("R7 zero-miss", 32'h0001_0000, 2'd0);
    check("R7 miss", {31'd0, rsp_hit}, 32'd0);
  endtask

  task automatic t_idle;
    @(negedge clk);
    check("R2 idle", {31'd0, rsp_valid}, 32'd0);
    check("R10 idle hit", {31'd0, rsp_hit}, 32'd0);
  endtask

  task automatic t_window_a;
    cfg_write(2'd2, 16'h3000);
    cfg_write(2'd0, 16'h0E00);
    cfg_write(2'd3, 16'hFE00);
    cfg_write(2'd1, 16'h01FF);
    do_req("R4 winA lo", 32'h0E00_0000, 2'd2);
    check("R4 winA lo abs", rsp_addr, 32'h3000_0000);
    do_req("R4 winA hi", 32'h0FFF_FFFF, 2'd0);
    check("R4 winA hi abs", rsp_addr, 32'h31FF_FFFF);
    do_req("R3 winA below", 32'h0DFF_FFFF, 2'd1);
    check("R3 winA below miss", {31'd0, rsp_hit}, 32'd0);
    do_req("R3 winA above", 32'h1000_0000, 2'd1);
    check("R3 winA above miss", {31'd0, rsp_hit}, 32'd0);
  endtask

  task automatic t_window_b;
    cfg_write(2'd0, 16'hFCE0);
    cfg_write(2'd3, 16'hFFE0);
    cfg_write(2'd1, 16'h001F);
    check("R8 tbase kept", {16'd0, m_tbase}, 32'h3000);
    do_req("R4 winB lo", 32'hFCE0_0010, 2'd0);
    check("R4 winB lo abs", rsp_addr, 32'h3000_0010);
    do_req("R4 winB hi", 32'hFCFF_FFFC, 2'd2);
    check("R4 winB hi abs", rsp_addr, 32'h301F_FFFC);
    do_req("R3 winB miss", 32'hFD00_0000, 2'd2);
    check("R3 winB miss flag", {31'd0, rsp_hit}, 32'd0);
  endtask

  task automatic t_collision;
    // same cycle: write match base 0x1234 while requesting an address hit under 0xFCE0
    logic [31:0] a;
    a = 32'hFCE4_5678;
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'd0; cfg_wdata = 16'h1234;
    req_valid = 1'b1; req_addr = a; req_size = 2'd1;
    @(negedge clk);
    cfg_we = 1'b0; req_valid = 1'b0;
    check("R9 old window hit", {31'd0, rsp_hit}, 32'd1);
    check("R9 old window addr", rsp_addr, 32'h3004_5678);
    model_set(2'd0, 16'h1234);
    do_req("R9 new window", a, 2'd1);
    check("R9 new window miss", {31'd0, rsp_hit}, 32'd0);
  endtask

  initial begin
    rst = 1'b1; cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
    req_valid = 1'b0; req_addr = '0; req_size = '0;
    m_mbase = '0; m_ign = '0; m_tbase = '0; m_subst = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset;
    t_zero_cfg;
    t_idle;
    t_window_a;
    t_window_b;
    t_collision;
    t_idle;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule